// File: doc/BRIEF.md
# Battery Temperature Zone Charge Controller

This block sits between four thermistor comparator flags and the charge engine of a battery charger. It sorts the battery temperature into one of five zones: normal, cool, warm, cold and hot. For each zone it produces the charge-control outputs: a charge suspend, a safety-timer pause, a reduced-current select, a regulation-voltage offset and a trickle-charge enable. The thermistor is NTC, so a higher sense voltage means a colder battery. The comparator flags are already oriented so that each flag means "past that temperature limit".

A low sense pin is also used as a push-button input. While charging is active and the button flag is high, charging pauses. Charging resumes as soon as the flag clears. A master enable bit turns off only the zone-driven charge actions. The zone status bits and interrupts keep following the comparators.

In the warm zone the effective regulation target is the stored voltage setting minus 100 mV or 200 mV. The stored setting is an input and is never modified. An open-pin clamp flag drives its own status bit regardless of the enable bit. A single-cycle interrupt pulse reports every change of zone or open-pin state, unless the mask bit is set.

Top module: `tzc_top`

## Requirements
- R1: The zone is encoded on `zone` as 0 normal, 1 cool, 2 warm, 3 cold, 4 hot, with priority cold > hot > cool > warm > normal. Each of `st_cold`, `st_cool`, `st_warm` and `st_hot` is high exactly when `zone` holds its zone. Every output reflects the inputs sampled at the previous rising clock edge.
- R2: When `cfg_en` is 1 and the zone is cold or hot, `chg_suspend` and `tmr_pause` are both 1.
- R3: When `cfg_en` is 1 and the zone is cool, `cur_reduce` is 1, `cur_sel` equals `cfg_cool_sel`, and `trickle_en` stays 1. In every other zone, `cur_reduce` and `cur_sel` are 0.
- R4: When `cfg_en` is 1 and the zone is warm, `vofs` is 2'b01 (-100 mV) if `cfg_warm_deep` is 0 and 2'b10 (-200 mV) if it is 1. Otherwise `vofs` is 2'b00.
- R5: `vbat_eff` equals `vbat_set` (LSB 10 mV) minus the `vofs` offset (10 or 20 LSBs), clamped at 0. `vbat_set` itself is an input that the block never alters.
- R6: When `cfg_en` is 0, `tmr_pause`, `cur_reduce` and `vofs` are 0, and no zone suspends charging. The zone and status bits still follow the comparator flags.
- R7: `trickle_en` is 0 whenever charging is suspended for any reason, and 1 otherwise.
- R8: `st_open` follows `clamp_on` regardless of `cfg_en`.
- R9: `irq` is a one-cycle pulse, issued in the cycle when a new zone or a new `st_open` value first appears. `irq` stays 0 while `int_mask` is 1.
- R10: While `charging` and `btn_low` are both 1, `chg_suspend` is 1. Charging resumes when `btn_low` returns to 0. `btn_low` has no effect while `charging` is 0.
- R11: Synchronous active-high `rst` sets zone normal, no suspend, no pause, no offset, `vbat_eff` 0, `trickle_en` 1, and all status bits and `irq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_cold | input | 1 | Sense voltage above cold limit |
| cmp_cool | input | 1 | Sense voltage above cool limit |
| cmp_warm | input | 1 | Sense voltage below warm limit |
| cmp_hot | input | 1 | Sense voltage below hot limit |
| clamp_on | input | 1 | Open-pin clamp active |
| btn_low | input | 1 | Sense pin held low (button pressed) |
| charging | input | 1 | Charger is in an active charge phase |
| cfg_en | input | 1 | Enables zone-driven charge actions |
| cfg_cool_sel | input | 1 | Reduced-current factor select for the cool zone |
| cfg_warm_deep | input | 1 | Warm offset select: 0 = 100 mV, 1 = 200 mV |
| int_mask | input | 1 | Suppresses the interrupt pulse |
| vbat_set | input | VBAT_W | Stored regulation voltage setting, 10 mV per LSB |
| zone | output | 3 | Current zone code |
| chg_suspend | output | 1 | Charging suspended |
| tmr_pause | output | 1 | Safety timer paused |
| cur_reduce | output | 1 | Reduced charge current active |
| cur_sel | output | 1 | Reduced-current factor in use |
| vofs | output | 2 | Regulation offset code |
| vbat_eff | output | VBAT_W | Effective regulation target |
| trickle_en | output | 1 | Trickle charge allowed |
| st_cold | output | 1 | Cold zone status |
| st_cool | output | 1 | Cool zone status |
| st_warm | output | 1 | Warm zone status |
| st_hot | output | 1 | Hot zone status |
| st_open | output | 1 | Open-pin status |
| irq | output | 1 | Interrupt pulse |

## Verification
On every cycle, the assertions check the per-cycle relations between inputs and the following outputs: cold priority, suspend and timer pause in the blocking zones, the enable bit removing all actions, the open-pin status tracking the clamp, and the mask keeping the interrupt quiet. Some behaviour can only be shown by the bench scenarios: the exact offset codes and clamped voltage arithmetic, the reduced-current factor, the single-cycle shape of the interrupt across a sequence of zone changes, and the button pausing and then resuming charging.

// File: rtl/tzc_pkg.sv
package tzc_pkg;

    typedef enum logic [2:0] {
        ZN_NORMAL = 3'd0,
        ZN_COOL   = 3'd1,
        ZN_WARM   = 3'd2,
        ZN_COLD   = 3'd3,
        ZN_HOT    = 3'd4
    } zone_e;

    typedef enum logic [1:0] {
        VO_NONE = 2'd0,
        VO_ONE  = 2'd1,
        VO_TWO  = 2'd2
    } vofs_e;

    typedef struct packed {
        logic cold;
        logic cool;
        logic warm;
        logic hot;
    } cmp_s;

    typedef struct packed {
        logic  suspend;
        logic  tmr_pause;
        logic  cur_reduce;
        logic  cur_sel;
        vofs_e vofs;
        logic  trickle_en;
    } act_s;

    localparam act_s ACT_IDLE = '{suspend: 1'b0, tmr_pause: 1'b0, cur_reduce: 1'b0,
                                  cur_sel: 1'b0, vofs: VO_NONE, trickle_en: 1'b1};

    function automatic logic zone_blocks(zone_e z);
        return (z == ZN_COLD) || (z == ZN_HOT);
    endfunction

endpackage

// File: rtl/tzc_zone_classify.sv
module tzc_zone_classify
    import tzc_pkg::*;
(
    input  cmp_s  cmp,
    output zone_e zone
);
    always_comb begin
        if (cmp.cold)      zone = ZN_COLD;
        else if (cmp.hot)  zone = ZN_HOT;
        else if (cmp.cool) zone = ZN_COOL;
        else if (cmp.warm) zone = ZN_WARM;
        else               zone = ZN_NORMAL;
    end
endmodule

// File: rtl/tzc_charge_action.sv
module tzc_charge_action
    import tzc_pkg::*;
(
    input  zone_e zone,
    input  logic  en,
    input  logic  cool_sel,
    input  logic  warm_deep,
    input  logic  charging,
    input  logic  btn_low,
    output act_s  act
);
    logic zone_stop;
    logic btn_stop;

    always_comb begin
        zone_stop = en && zone_blocks(zone);
        btn_stop  = charging && btn_low;
        act       = ACT_IDLE;
        act.suspend    = zone_stop || btn_stop;
        act.tmr_pause  = zone_stop;
        act.trickle_en = !(zone_stop || btn_stop);
        if (en && zone == ZN_COOL) begin
            act.cur_reduce = 1'b1;
            act.cur_sel    = cool_sel;
        end
        if (en && zone == ZN_WARM) begin
            act.vofs = warm_deep ? VO_TWO : VO_ONE;
        end
    end
endmodule

// File: rtl/tzc_vtarget.sv
module tzc_vtarget
    import tzc_pkg::*;
#(
    parameter int VBAT_W = 10,
    parameter int STEP   = 10
) (
    input  logic [VBAT_W-1:0] vset,
    input  vofs_e             vofs,
    output logic [VBAT_W-1:0] veff
);
    localparam int CW = VBAT_W + 2;
    localparam logic [CW-1:0] SUB_ONE = CW'(STEP);
    localparam logic [CW-1:0] SUB_TWO = CW'(2 * STEP);

    logic [CW-1:0] sub;
    logic [CW-1:0] wide;
    logic [CW-1:0] diff;

    always_comb begin
        case (vofs)
            VO_ONE:  sub = SUB_ONE;
            VO_TWO:  sub = SUB_TWO;
            default: sub = '0;
        endcase
        wide = {2'b00, vset};
        diff = wide - sub;
        veff = (wide >= sub) ? diff[VBAT_W-1:0] : '0;
    end
endmodule

// File: rtl/tzc_event.sv
module tzc_event
    import tzc_pkg::*;
(
    input  zone_e zone_nx,
    input  zone_e zone_q,
    input  logic  open_nx,
    input  logic  open_q,
    input  logic  mask,
    output logic  pulse
);
    always_comb begin
        pulse = !mask && ((zone_nx != zone_q) || (open_nx != open_q));
    end
endmodule

// File: rtl/tzc_top.sv
module tzc_top
    import tzc_pkg::*;
#(
    parameter int VBAT_W      = 10,
    parameter int VBAT_LSB_MV = 10,
    parameter int OFS_STEP_MV = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_cold,
    input  logic              cmp_cool,
    input  logic              cmp_warm,
    input  logic              cmp_hot,
    input  logic              clamp_on,
    input  logic              btn_low,
    input  logic              charging,
    input  logic              cfg_en,
    input  logic              cfg_cool_sel,
    input  logic              cfg_warm_deep,
    input  logic              int_mask,
    input  logic [VBAT_W-1:0] vbat_set,
    output logic [2:0]        zone,
    output logic              chg_suspend,
    output logic              tmr_pause,
    output logic              cur_reduce,
    output logic              cur_sel,
    output logic [1:0]        vofs,
    output logic [VBAT_W-1:0] vbat_eff,
    output logic              trickle_en,
    output logic              st_cold,
    output logic              st_cool,
    output logic              st_warm,
    output logic              st_hot,
    output logic              st_open,
    output logic              irq
);
    localparam int STEP_LSB = OFS_STEP_MV / VBAT_LSB_MV;

    cmp_s              cmp;
    zone_e             zone_nx, zone_q;
    act_s              act_nx, act_q;
    logic [VBAT_W-1:0] veff_nx, veff_q;
    logic              open_q;
    logic              pulse_nx, irq_q;

    assign cmp = '{cold: cmp_cold, cool: cmp_cool, warm: cmp_warm, hot: cmp_hot};

    tzc_zone_classify i_classify (
        .cmp  (cmp),
        .zone (zone_nx)
    );

    tzc_charge_action i_action (
        .zone      (zone_nx),
        .en        (cfg_en),
        .cool_sel  (cfg_cool_sel),
        .warm_deep (cfg_warm_deep),
        .charging  (charging),
        .btn_low   (btn_low),
        .act       (act_nx)
    );

    tzc_vtarget #(.VBAT_W(VBAT_W), .STEP(STEP_LSB)) i_vtarget (
        .vset (vbat_set),
        .vofs (act_nx.vofs),
        .veff (veff_nx)
    );

    tzc_event i_event (
        .zone_nx (zone_nx),
        .zone_q  (zone_q),
        .open_nx (clamp_on),
        .open_q  (open_q),
        .mask    (int_mask),
        .pulse   (pulse_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            zone_q <= ZN_NORMAL;
            act_q  <= ACT_IDLE;
            veff_q <= '0;
            open_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            zone_q <= zone_nx;
            act_q  <= act_nx;
            veff_q <= veff_nx;
            open_q <= clamp_on;
            irq_q  <= pulse_nx;
        end
    end

    assign zone        = zone_q;
    assign chg_suspend = act_q.suspend;
    assign tmr_pause   = act_q.tmr_pause;
    assign cur_reduce  = act_q.cur_reduce;
    assign cur_sel     = act_q.cur_sel;
    assign vofs        = act_q.vofs;
    assign vbat_eff    = veff_q;
    assign trickle_en  = act_q.trickle_en;
    assign st_cold     = (zone_q == ZN_COLD);
    assign st_cool     = (zone_q == ZN_COOL);
    assign st_warm     = (zone_q == ZN_WARM);
    assign st_hot      = (zone_q == ZN_HOT);
    assign st_open     = open_q;
    assign irq         = irq_q;
endmodule

// File: rtl/tzc_checker.sv
module tzc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmp_cold,
    input logic       cmp_hot,
    input logic       clamp_on,
    input logic       charging,
    input logic       btn_low,
    input logic       cfg_en,
    input logic       int_mask,
    input logic [2:0] zone,
    input logic       chg_suspend,
    input logic       tmr_pause,
    input logic       cur_reduce,
    input logic [1:0] vofs,
    input logic       trickle_en,
    input logic       st_cold,
    input logic       st_open,
    input logic       irq
);
    a_r1_cold_priority: assert property (@(posedge clk) disable iff (rst)
        cmp_cold |=> (zone == 3'd3) && st_cold);

    a_r2_block_suspend: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && (cmp_cold || cmp_hot)) |=> chg_suspend && tmr_pause);

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> !tmr_pause && !cur_reduce && (vofs == 2'b00));

    a_r7_block_no_trickle: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cmp_hot) |=> !trickle_en);

    a_r8_open_follows: assert property (@(posedge clk) disable iff (rst)
        clamp_on |=> st_open);

    a_r9_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        int_mask |=> !irq);

    a_r10_button_pause: assert property (@(posedge clk) disable iff (rst)
        (charging && btn_low) |=> chg_suspend && !trickle_en);
endmodule

bind tzc_top tzc_checker i_tzc_checker (
    .clk         (clk),
    .rst         (rst),
    .cmp_cold    (cmp_cold),
    .cmp_hot     (cmp_hot),
    .clamp_on    (clamp_on),
    .charging    (charging),
    .btn_low     (btn_low),
    .cfg_en      (cfg_en),
    .int_mask    (int_mask),
    .zone        (zone),
    .chg_suspend (chg_suspend),
    .tmr_pause   (tmr_pause),
    .cur_reduce  (cur_reduce),
    .vofs        (vofs),
    .trickle_en  (trickle_en),
    .st_cold     (st_cold),
    .st_open     (st_open),
    .irq         (irq)
);

// File: tb/test_tzc_top.sv
`timescale 1ns/1ps
module test_tzc_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmp_cold, cmp_cool, cmp_warm, cmp_hot;
    logic       clamp_on, btn_low, charging;
    logic       cfg_en, cfg_cool_sel, cfg_warm_deep, int_mask;
    logic [9:0] vbat_set;
    logic [2:0] zone;
    logic       chg_suspend, tmr_pause, cur_reduce, cur_sel;
    logic [1:0] vofs;
    logic [9:0] vbat_eff;
    logic       trickle_en, st_cold, st_cool, st_warm, st_hot, st_open, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tzc_top i_tzc_top (
        .clk(clk), .rst(rst),
        .cmp_cold(cmp_cold), .cmp_cool(cmp_cool), .cmp_warm(cmp_warm), .cmp_hot(cmp_hot),
        .clamp_on(clamp_on), .btn_low(btn_low), .charging(charging),
        .cfg_en(cfg_en), .cfg_cool_sel(cfg_cool_sel), .cfg_warm_deep(cfg_warm_deep),
        .int_mask(int_mask), .vbat_set(vbat_set),
        .zone(zone), .chg_suspend(chg_suspend), .tmr_pause(tmr_pause),
        .cur_reduce(cur_reduce), .cur_sel(cur_sel), .vofs(vofs), .vbat_eff(vbat_eff),
        .trickle_en(trickle_en), .st_cold(st_cold), .st_cool(st_cool), .st_warm(st_warm),
        .st_hot(st_hot), .st_open(st_open), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // drive flags at the falling edge, let one rising edge pass, sample 1 ns later
    task automatic apply(input logic c, input logic co, input logic w, input logic h);
        @(negedge clk);
        cmp_cold = c; cmp_cool = co; cmp_warm = w; cmp_hot = h;
        @(posedge clk);
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        cmp_cold = 1'b1; clamp_on = 1'b1;
        @(posedge clk); #1;
        chk("R11", "zone", zone, 0);
        chk("R11", "suspend", chg_suspend, 0);
        chk("R11", "pause", tmr_pause, 0);
        chk("R11", "vofs", vofs, 0);
        chk("R11", "vbat_eff", vbat_eff, 0);
        chk("R11", "trickle", trickle_en, 1);
        chk("R11", "status", {st_cold, st_cool, st_warm, st_hot, st_open, irq}, 0);
        @(negedge clk);
        cmp_cold = 1'b0; clamp_on = 1'b0;
        rst = 1'b0;
        tick();
    endtask

    task automatic t_zones();
        apply(1, 0, 0, 0);
        chk("R1", "cold code", zone, 3);
        chk("R1", "cold status", {st_cold, st_cool, st_warm, st_hot}, 4'b1000);
        chk("R2", "cold suspend", {chg_suspend, tmr_pause}, 2'b11);
        chk("R7", "cold trickle", trickle_en, 0);
        apply(0, 0, 0, 1);
        chk("R1", "hot code", zone, 4);
        chk("R2", "hot suspend", {chg_suspend, tmr_pause}, 2'b11);
        chk("R1", "hot status", {st_cold, st_cool, st_warm, st_hot}, 4'b0001);
        apply(1, 1, 1, 1);
        chk("R1", "cold beats all", zone, 3);
        apply(0, 1, 1, 1);
        chk("R1", "hot beats cool", zone, 4);
        apply(0, 1, 1, 0);
        chk("R1", "cool beats warm", zone, 1);
        apply(0, 0, 0, 0);
        chk("R1", "normal code", zone, 0);
        chk("R2", "normal no suspend", {chg_suspend, tmr_pause}, 2'b00);
    endtask

    task automatic t_cool();
        @(negedge clk); cfg_cool_sel = 1'b1;
        apply(0, 1, 0, 0);
        chk("R3", "cool reduce", cur_reduce, 1);
        chk("R3", "cool sel 1", cur_sel, 1);
        chk("R3", "cool trickle kept", trickle_en, 1);
        chk("R3", "cool no suspend", chg_suspend, 0);
        @(negedge clk); cfg_cool_sel = 1'b0;
        tick();
        chk("R3", "cool sel 0", cur_sel, 0);
        apply(0, 0, 0, 0);
        chk("R3", "normal no reduce", {cur_reduce, cur_sel}, 0);
    endtask

    task automatic t_warm();
        @(negedge clk); vbat_set = 10'd420; cfg_warm_deep = 1'b0;
        apply(0, 0, 1, 0);
        chk("R4", "warm 100 code", vofs, 1);
        chk("R5", "warm 100 target", vbat_eff, 410);
        @(negedge clk); cfg_warm_deep = 1'b1;
        tick();
        chk("R4", "warm 200 code", vofs, 2);
        chk("R5", "warm 200 target", vbat_eff, 400);
        @(negedge clk); vbat_set = 10'd15;
        tick();
        chk("R5", "clamped target", vbat_eff, 0);
        @(negedge clk); vbat_set = 10'd20;
        tick();
        chk("R5", "exact zero target", vbat_eff, 0);
        @(negedge clk); vbat_set = 10'd420;
        apply(0, 0, 0, 0);
        chk("R4", "normal code", vofs, 0);
        chk("R5", "normal target", vbat_eff, 420);
    endtask

    task automatic t_disable();
        @(negedge clk); cfg_en = 1'b0; cfg_cool_sel = 1'b1;
        apply(1, 0, 0, 0);
        chk("R6", "cold no suspend", {chg_suspend, tmr_pause}, 0);
        chk("R6", "cold status kept", st_cold, 1);
        chk("R6", "cold trickle", trickle_en, 1);
        apply(0, 0, 1, 0);
        chk("R6", "warm no offset", vofs, 0);
        chk("R6", "warm target", vbat_eff, 420);
        chk("R6", "warm status kept", st_warm, 1);
        apply(0, 1, 0, 0);
        chk("R6", "cool no reduce", {cur_reduce, cur_sel}, 0);
        @(negedge clk); cfg_en = 1'b1; cfg_cool_sel = 1'b0;
        apply(0, 0, 0, 0);
    endtask

    task automatic t_open();
        @(negedge clk); cfg_en = 1'b0; clamp_on = 1'b1;
        @(posedge clk); #1;
        chk("R8", "open set with en off", st_open, 1);
        chk("R9", "open irq", irq, 1);
        tick();
        chk("R9", "open irq single", irq, 0);
        @(negedge clk); clamp_on = 1'b0;
        @(posedge clk); #1;
        chk("R8", "open clear", st_open, 0);
        chk("R9", "open clear irq", irq, 1);
        @(negedge clk); cfg_en = 1'b1;
        tick();
    endtask

    task automatic t_irq();
        apply(0, 1, 0, 0);
        chk("R9", "zone change irq", irq, 1);
        tick();
        chk("R9", "irq one cycle", irq, 0);
        apply(0, 0, 1, 0);
        chk("R9", "back to back change", irq, 1);
        apply(0, 0, 1, 0);
        chk("R9", "steady no irq", irq, 0);
        @(negedge clk); int_mask = 1'b1;
        apply(0, 0, 0, 1);
        chk("R9", "masked irq", irq, 0);
        chk("R9", "masked status", st_hot, 1);
        @(negedge clk); clamp_on = 1'b1;
        @(posedge clk); #1;
        chk("R9", "masked open irq", irq, 0);
        @(negedge clk); clamp_on = 1'b0;
        apply(0, 0, 0, 0);
        @(negedge clk); int_mask = 1'b0;
        tick();
    endtask

    task automatic t_button();
        @(negedge clk); charging = 1'b1; btn_low = 1'b1;
        @(posedge clk); #1;
        chk("R10", "button suspends", chg_suspend, 1);
        chk("R7", "button trickle off", trickle_en, 0);
        chk("R10", "button no pause", tmr_pause, 0);
        tick();
        chk("R10", "held suspends", chg_suspend, 1);
        @(negedge clk); btn_low = 1'b0;
        @(posedge clk); #1;
        chk("R10", "release resumes", chg_suspend, 0);
        chk("R7", "release trickle", trickle_en, 1);
        @(negedge clk); charging = 1'b0; btn_low = 1'b1;
        @(posedge clk); #1;
        chk("R10", "idle button ignored", chg_suspend, 0);
        @(negedge clk); btn_low = 1'b0;
        tick();
    endtask

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmp_cold = 0; cmp_cool = 0; cmp_warm = 0; cmp_hot = 0;
        clamp_on = 0; btn_low = 0; charging = 0;
        cfg_en = 1; cfg_cool_sel = 0; cfg_warm_deep = 0; int_mask = 0;
        vbat_set = 10'd420;
        repeat (3) @(posedge clk);
        t_reset();
        t_zones();
        t_cool();
        t_warm();
        t_disable();
        t_open();
        t_irq();
        t_button();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule